// File: doc/BRIEF.md
# Machine Status Register Write Legalizer

This block holds the machine-level status word of a processor hart and filters every software write into it. A write is accepted only into the fields that are legal for the selected privilege-spec version. A write that names a privilege mode the hart cannot enter is refused for the previous-mode field only. The dirty-summary bit at the top of the word is always recomputed from the extension-state fields, so software cannot set or clear it directly.

A second, supervisor-level view reads and writes a masked window of the same word. A write through that view first merges its visible fields into the held word and then goes through the same legalization as a machine-level write. Each write is decoded into one of three write kinds: `OP_HOLD` (no write this cycle), `OP_MACH` (full-word write) or `OP_SUPV` (windowed write). Every clock edge takes the hold path unless the strobe is high.

When a write asks for a value that differs from the held word in any address-translation-relevant field, the block raises a one-cycle flush pulse. The surrounding pipeline uses that pulse to invalidate cached translations.

Top module: `stat_legalizer`

## Requirements
- R1: A write updates only the writable fields: SIE (bit 1), MIE (3), SPIE (5), MPIE (7), SPP (8), MPP (12:11), FS (14:13), MPRV (17), SUM (18) and MXR (19). Every other bit below the top bit reads 0, and the word is unchanged in any cycle without a write.
- R2: MPP encodes 0 = user, 1 = supervisor, 2 = reserved, 3 = machine. A write requesting 2 leaves MPP unchanged. So does a write requesting 1 while `has_smode` is 0, or a write requesting 0 while `has_umode` is 0. The other fields of such a write are still applied.
- R3: The top bit (SD) is 1 exactly when FS (14:13) equals 3 or XS (16:15) equals 3. It is recomputed on every write, and its written value is ignored.
- R4: `flush_pulse` is high for exactly the one cycle after a write whose requested value differs from the held word in MXR, MPP, MPRV or SUM. The requested value is compared, even when legalization later discards its MPP part.
- R5: `sview_rd` equals the held word masked to UIE (0), SIE (1), UPIE (4), SPIE (5), SPP (8), FS, XS, SUM (18) and SD. MXR (19) is also visible when `spec_new` is 1.
- R6: TVM (20), TW (21) and TSR (22) are writable only when `spec_new` is 1. Otherwise they keep their value.
- R7: A write with `wr_sview` set changes only fields inside the current supervisor window, and SD is then recomputed. MIE, MPIE, MPP, MPRV and the TVM/TW/TSR group keep their values.
- R8: After reset the word is 0x1800 (MPP = 3, all else 0) and `flush_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sview | input | 1 | 1: write through the supervisor window, 0: full-word write |
| spec_new | input | 1 | 1: newer privilege-spec field set, 0: older |
| has_smode | input | 1 | Hart supports supervisor mode |
| has_umode | input | 1 | Hart supports user mode |
| wr_data | input | XLEN | Write data |
| status_q | output | XLEN | Held status word |
| sview_rd | output | XLEN | Supervisor-window read value |
| flush_pulse | output | 1 | One-cycle translation flush request |

## Verification
MPP refusal and flush detection can both fall on the same write. The bench provokes this by writing the reserved mode 2, and unsupported modes, while MPP holds a different value. The scoreboard then expects MPP to stay put in the following cycle while `flush_pulse` still rises. A supervisor-window write that sets FS to 3 likewise exercises the merge and the SD recompute in one cycle. The bench judges it by checking that SD, MXR and the untouched machine fields all land correctly together.

// File: rtl/stat_pkg.sv
package stat_pkg;

    // field positions inside the status word
    localparam int B_UIE    = 0;
    localparam int B_SIE    = 1;
    localparam int B_MIE    = 3;
    localparam int B_UPIE   = 4;
    localparam int B_SPIE   = 5;
    localparam int B_MPIE   = 7;
    localparam int B_SPP    = 8;
    localparam int B_MPP_LO = 11;
    localparam int B_FS_LO  = 13;
    localparam int B_XS_LO  = 15;
    localparam int B_MPRV   = 17;
    localparam int B_SUM    = 18;
    localparam int B_MXR    = 19;
    localparam int B_TVM    = 20;
    localparam int B_TW     = 21;
    localparam int B_TSR    = 22;

    // previous-mode encodings
    localparam logic [1:0] MODE_U   = 2'd0;
    localparam logic [1:0] MODE_S   = 2'd1;
    localparam logic [1:0] MODE_RSV = 2'd2;
    localparam logic [1:0] MODE_M   = 2'd3;

    // low-word masks (top SD bit handled separately)
    localparam logic [31:0] LO_MPP   = 32'h3 << B_MPP_LO;
    localparam logic [31:0] LO_FS    = 32'h3 << B_FS_LO;
    localparam logic [31:0] LO_XS    = 32'h3 << B_XS_LO;
    localparam logic [31:0] LO_WR_BASE =
        (32'd1 << B_SIE) | (32'd1 << B_MIE) | (32'd1 << B_SPIE) |
        (32'd1 << B_MPIE) | (32'd1 << B_SPP) | LO_MPP | LO_FS |
        (32'd1 << B_MPRV) | (32'd1 << B_SUM) | (32'd1 << B_MXR);
    localparam logic [31:0] LO_WR_NEWX =
        (32'd1 << B_TVM) | (32'd1 << B_TW) | (32'd1 << B_TSR);
    localparam logic [31:0] LO_SV_BASE =
        (32'd1 << B_UIE) | (32'd1 << B_SIE) | (32'd1 << B_UPIE) |
        (32'd1 << B_SPIE) | (32'd1 << B_SPP) | LO_FS | LO_XS |
        (32'd1 << B_SUM);
    localparam logic [31:0] LO_FLUSH =
        (32'd1 << B_MXR) | LO_MPP | (32'd1 << B_MPRV) | (32'd1 << B_SUM);

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_MACH = 2'd1,
        OP_SUPV = 2'd2
    } wr_op_e;

endpackage

// File: rtl/stat_mask_gen.sv
module stat_mask_gen
    import stat_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            spec_new,
    output logic [XLEN-1:0] wr_mask,
    output logic [XLEN-1:0] sv_mask
);
    localparam logic [XLEN-1:0] SD_BIT = XLEN'(1) << (XLEN - 1);

    always_comb begin
        wr_mask = XLEN'(LO_WR_BASE);
        sv_mask = XLEN'(LO_SV_BASE) | SD_BIT;
        if (spec_new) begin
            wr_mask = wr_mask | XLEN'(LO_WR_NEWX);
            sv_mask = sv_mask | (XLEN'(1) << B_MXR);
        end
    end
endmodule

// File: rtl/stat_mpp_check.sv
module stat_mpp_check
    import stat_pkg::*;
(
    input  logic [1:0] mpp_req,
    input  logic       has_smode,
    input  logic       has_umode,
    output logic       mpp_ok
);
    always_comb begin
        unique case (mpp_req)
            MODE_M:   mpp_ok = 1'b1;
            MODE_S:   mpp_ok = has_smode;
            MODE_U:   mpp_ok = has_umode;
            MODE_RSV: mpp_ok = 1'b0;
            default:  mpp_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/stat_core.sv
module stat_core
    import stat_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_go,
    input  logic [XLEN-1:0] next_val,
    input  logic            flush_req,
    output logic [XLEN-1:0] status_q,
    output logic            flush_q
);
    localparam logic [XLEN-1:0] RESET_VAL = XLEN'(LO_MPP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= RESET_VAL;
            flush_q  <= 1'b0;
        end else begin
            flush_q <= flush_req;
            if (wr_go) begin
                status_q <= next_val;
            end
        end
    end
endmodule

// File: rtl/stat_legalizer.sv
module stat_legalizer
    import stat_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sview,
    input  logic            spec_new,
    input  logic            has_smode,
    input  logic            has_umode,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] status_q,
    output logic [XLEN-1:0] sview_rd,
    output logic            flush_pulse
);
    localparam logic [XLEN-1:0] MPP_MASK   = XLEN'(LO_MPP);
    localparam logic [XLEN-1:0] FLUSH_MASK = XLEN'(LO_FLUSH);

    wr_op_e          op;
    logic [XLEN-1:0] wr_mask;
    logic [XLEN-1:0] sv_mask;
    logic [XLEN-1:0] req_val;
    logic [XLEN-1:0] eff_mask;
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] next_val;
    logic            mpp_ok;
    logic            sd_next;
    logic            flush_req;

    stat_mask_gen #(.XLEN(XLEN)) u_masks (
        .spec_new (spec_new),
        .wr_mask  (wr_mask),
        .sv_mask  (sv_mask)
    );

    // write-kind decode
    always_comb begin
        if (!wr_en)        op = OP_HOLD;
        else if (wr_sview) op = OP_SUPV;
        else               op = OP_MACH;
    end

    // requested full-word value for each write kind
    always_comb begin
        unique case (op)
            OP_SUPV: req_val = (status_q & ~sv_mask) | (wr_data & sv_mask);
            OP_MACH: req_val = wr_data;
            OP_HOLD: req_val = status_q;
            default: req_val = status_q;
        endcase
    end

    stat_mpp_check u_mpp (
        .mpp_req   (req_val[B_MPP_LO+1:B_MPP_LO]),
        .has_smode (has_smode),
        .has_umode (has_umode),
        .mpp_ok    (mpp_ok)
    );

    always_comb begin
        eff_mask  = mpp_ok ? wr_mask : (wr_mask & ~MPP_MASK);
        merged    = (status_q & ~eff_mask) | (req_val & eff_mask);
        sd_next   = (&merged[B_FS_LO+1:B_FS_LO]) | (&merged[B_XS_LO+1:B_XS_LO]);
        next_val  = {sd_next, merged[XLEN-2:0]};
        flush_req = (op != OP_HOLD) && (|((req_val ^ status_q) & FLUSH_MASK));
    end

    stat_core #(.XLEN(XLEN)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (op != OP_HOLD),
        .next_val  (next_val),
        .flush_req (flush_req),
        .status_q  (status_q),
        .flush_q   (flush_pulse)
    );

    assign sview_rd = status_q & sv_mask;
endmodule

// File: rtl/stat_legalizer_chk.sv
module stat_legalizer_chk
    import stat_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_sview,
    input logic            spec_new,
    input logic            has_smode,
    input logic            has_umode,
    input logic [XLEN-1:0] status_q,
    input logic [XLEN-1:0] sview_rd,
    input logic            flush_pulse
);
    localparam logic [XLEN-1:0] SD_BIT   = XLEN'(1) << (XLEN - 1);
    localparam logic [XLEN-1:0] ALL_WR   = XLEN'(LO_WR_BASE | LO_WR_NEWX);
    localparam logic [XLEN-1:0] SV_WIDE  = XLEN'(LO_SV_BASE) | (XLEN'(1) << B_MXR) | SD_BIT;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status_q)); // R1
    AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~(ALL_WR | SD_BIT)) == '0); // R1
    AST_MPP_NOT_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[B_MPP_LO+1:B_MPP_LO] != MODE_RSV); // R2
    AST_MPP_NO_SUP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !has_smode && status_q[B_MPP_LO+1:B_MPP_LO] != MODE_S)
        |=> status_q[B_MPP_LO+1:B_MPP_LO] != MODE_S); // R2
    AST_MPP_NO_USR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !has_umode && status_q[B_MPP_LO+1:B_MPP_LO] != MODE_U)
        |=> status_q[B_MPP_LO+1:B_MPP_LO] != MODE_U); // R2
    AST_SD_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[XLEN-1] == ((&status_q[B_FS_LO+1:B_FS_LO]) | (&status_q[B_XS_LO+1:B_XS_LO]))); // R3
    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> $past(wr_en)); // R4
    AST_SVIEW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sview_rd & ~SV_WIDE) == '0); // R5
    AST_SVIEW_OLD_MXR: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_new |-> !sview_rd[B_MXR]); // R5
    AST_NEW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !spec_new) |=> $stable(status_q[B_TSR:B_TVM])); // R6
    AST_SV_KEEPS_M: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sview) |=> ($stable(status_q[B_MIE]) && $stable(status_q[B_MPRV])
                                 && $stable(status_q[B_MPP_LO+1:B_MPP_LO]))); // R7
endmodule

bind stat_legalizer stat_legalizer_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/stat_legalizer_bench.sv
module stat_legalizer_bench;
    localparam int  XLEN       = 64;
    localparam time CLK_PERIOD = 10;

    localparam logic [63:0] WR_OLD = 64'h0000_0000_000E_79AA;
    localparam logic [63:0] WR_NEW = 64'h0000_0000_007E_79AA;
    localparam logic [63:0] SV_OLD = 64'h8000_0000_0005_E133;
    localparam logic [63:0] SV_NEW = 64'h8000_0000_000D_E133;
    localparam logic [63:0] FL_MSK = 64'h0000_0000_000E_1800;
    localparam logic [63:0] MPP_M  = 64'h0000_0000_0000_1800;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            wr_sview = 1'b0;
    logic            spec_new = 1'b1;
    logic            has_smode = 1'b1;
    logic            has_umode = 1'b1;
    logic [XLEN-1:0] wr_data = '0;
    logic [XLEN-1:0] status_q;
    logic [XLEN-1:0] sview_rd;
    logic            flush_pulse;

    typedef struct {
        logic [63:0] st;
        logic [63:0] sv;
        logic        fl;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [63:0] mstate;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    stat_legalizer #(.XLEN(XLEN)) u_stat_legalizer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sview(wr_sview),
        .spec_new(spec_new), .has_smode(has_smode), .has_umode(has_umode),
        .wr_data(wr_data), .status_q(status_q), .sview_rd(sview_rd),
        .flush_pulse(flush_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] svm();
        return spec_new ? SV_NEW : SV_OLD;
    endfunction

    task automatic check64(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: one write this cycle, expected result queued for the monitor
    task automatic drive(logic [63:0] data, logic sv, string tag);
        logic [63:0] req, wm, nx;
        logic [1:0]  mpp;
        logic        fl;
        req = sv ? ((mstate & ~svm()) | (data & svm())) : data;
        wm  = spec_new ? WR_NEW : WR_OLD;
        mpp = req[12:11];
        if (mpp == 2'd2 || (mpp == 2'd1 && !has_smode) || (mpp == 2'd0 && !has_umode))
            wm = wm & ~MPP_M;
        fl = |((req ^ mstate) & FL_MSK);
        nx = (mstate & ~wm) | (req & wm);
        nx[63] = (nx[14:13] == 2'd3) || (nx[16:15] == 2'd3);
        mstate = nx;
        wr_en = 1'b1; wr_data = data; wr_sview = sv;
        exp_q.push_back('{mstate, mstate & svm(), fl, tag});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(string tag);
        wr_en = 1'b0;
        exp_q.push_back('{mstate, mstate & svm(), 1'b0, tag});
        @(negedge clk);
    endtask

    // monitor: compare one queued item after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check64(e.tag, "status", status_q, e.st);
                check64(e.tag, "sview", sview_rd, e.sv);
                check64(e.tag, "flush", 64'(flush_pulse), 64'(e.fl));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        check64("R8", "status", status_q, 64'h1800);
        check64("R8", "flush", 64'(flush_pulse), 64'd0);
        check64("R8", "sview", sview_rd, 64'd0);
        mstate = 64'h1800;

        // R1 R3 R4 R6: full-word write of all ones, newer spec
        drive('1, 1'b0, "R1_R3_R4_R6 all ones");
        idle("R1 hold after write");
        // R2 reserved mode with flush in the same write
        drive(64'h1000, 1'b0, "R2_R4 reserved MPP");
        drive(64'h0, 1'b0, "R4 MPP to user");
        drive(64'h0, 1'b0, "R4 same value no flush");
        drive(64'h8, 1'b0, "R4 MIE only no flush");
        // R2 unsupported modes
        has_smode = 1'b0;
        drive(64'h0800, 1'b0, "R2 sup unsupported");
        has_smode = 1'b1;
        drive(64'h1800, 1'b0, "R2 machine legal");
        has_umode = 1'b0;
        drive(64'h0, 1'b0, "R2 user unsupported");
        has_umode = 1'b1;
        drive(64'h0800, 1'b0, "R2 sup supported");
        // R7 R5 supervisor window write, newer spec
        drive(64'h0, 1'b0, "R1 clear");
        drive(64'h00A8, 1'b0, "R7 set MIE MPIE");
        drive('1, 1'b1, "R7_R3_R5 sview all ones");
        spec_new = 1'b0;
        idle("R5 older view hides MXR");
        // R6 older spec
        drive('1, 1'b0, "R6 older all ones");
        drive(64'h0, 1'b1, "R7 older sview clear keeps MXR");
        spec_new = 1'b1;
        drive(64'h0070_0000, 1'b0, "R6 newer trap bits");
        // R3 summary
        drive(64'h2000, 1'b0, "R3 FS one no SD");
        drive(64'h6000, 1'b0, "R3 FS three SD");
        drive(64'h2000, 1'b1, "R3 sview FS one clears SD");
        drive(64'h4_0000, 1'b0, "R4 SUM flush");
        idle("R4 pulse ends");
        idle("R1 final hold");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule